// File: doc/BRIEF.md
# Random Center-Displacement PWM Generator

This block drives one power switch at a fixed switching frequency. Time is counted on a timebase of 4R ticks per switching period, and the ticks arrive as single-clock enables (`tick_en`) from a divider outside the block. At the start of each period the block samples a signed reference once. It clamps the reference to [-R, R] and turns it straight into two edge instants. No carrier waveform is generated: the low pulse runs from tick R+u to tick 3R-u, so it sits symmetrically about the middle of the period.

In random mode, a 16-bit maximal-length LFSR gives a value n in [-100, 100] once per period. The block then moves the pulse by trunc(b·n/100) ticks, where b is the largest shift that still keeps the pulse inside the period. A polarity input picks which pulse is centered and moved. For the low pulse, b = R+u, which is d·T/2. For the high pulse, b = R-u, which is (1-d)·T/2. Both edges move by the same amount, so the duty cycle is kept and the pulse never crosses into a neighbouring period.

Top module: `rcd_pwm`

## Requirements
- R1: While reset is asserted, and afterwards until the first `tick_en`, `pwm_out` and `period_start` are both 0.
- R2: A period lasts exactly 4R ticks. The tick that ends one period (counter at 4R-1) starts the next, and `period_start` is high for exactly the one clock after that tick. The first tick after reset starts a period.
- R3: While `tick_en` is low the tick counter holds, `pwm_out` stays constant and no `period_start` occurs, so the period is stretched by the held clocks.
- R4: In deterministic mode (`rand_mode`=0), with clamped reference u, the output is low for tick counts in [R+u, 3R-u) and high elsewhere. `pwm_out` shows the counter value one clock late.
- R5: The reference, `rand_mode` and `disp_high` are sampled only on the period-starting tick. Changes during a period do not affect that period.
- R6: A reference above R acts as R, and a reference below -R acts as -R.
- R7: At u=R the output stays high for the whole period, and at u=-R it stays low for the whole period, in every mode and polarity.
- R8: The LFSR resets to 0xACE1 and shifts left once per period-starting tick, inserting bit15^bit13^bit12^bit10 (x^16+x^14+x^13+x^11+1). In random mode, n = (state before the shift mod 201) - 100, and Δ = trunc(b·n/100) with truncation toward zero. With `disp_high`=0 the low window is [b+Δ, 4R-b+Δ), where b=R+u.
- R9: In random mode with `disp_high`=1, the output is high in the window [b+Δ, 4R-b+Δ), where b=R-u, and low elsewhere.
- R10: In every mode, the output is high for exactly 2(R+u) ticks of each period.
- R11: In random mode with a reference away from ±R, the position of the pulse changes from period to period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-clock enable per PWM timebase tick |
| ref_in | input | 9 | Signed reference, meaningful range [-R, R] |
| rand_mode | input | 1 | 0 = deterministic center-aligned, 1 = random displacement |
| disp_high | input | 1 | In random mode: 0 moves the low pulse, 1 moves the high pulse |
| pwm_out | output | 1 | Switch-drive signal |
| period_start | output | 1 | One-clock strobe after each period-starting tick |

## Verification
The period-starting tick updates the counter and the edge registers at the same clock edge. `period_start` rises one clock after that tick. `pwm_out` follows the counter with one extra register, so the output for tick count k appears one clock after the counter reaches k. The bench samples on the falling clock edge. It treats the sample taken at a strobe as the last tick of the previous period, and the next 4R samples as counts 0 to 4R-1. New inputs are applied at a strobe and checked only over the period after the next one. This is how a mid-period change is shown to wait for the boundary. High-tick totals, first-low positions and period lengths are counted over these aligned windows. A cycle model, clocked on the rising edge, supplies the expected output for each sample.

// File: rtl/rcd_pwm.sv
module rcd_pwm #(
  parameter int R = 250,
  parameter int RW = 9,
  parameter int NMAX = 100,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic signed [RW-1:0] ref_in,
  input  logic                 rand_mode,
  input  logic                 disp_high,
  output logic                 pwm_out,
  output logic                 period_start
);
  localparam int PER = 4 * R;
  localparam int CW = $clog2(PER + 1);
  localparam int NSPAN = 2 * NMAX + 1;

  logic [CW-1:0] cnt, e1, e2;
  logic          inner;
  logic [15:0]   lfsr;
  logic          boundary, hi_mode;
  logic signed [31:0] u, uc, b, n, dsp, s1, s2;

  assign boundary = tick_en && (cnt == CW'(PER - 1));
  assign hi_mode  = rand_mode && disp_high;

  assign u   = 32'(ref_in);
  assign uc  = (u > R) ? R : ((u < -R) ? -R : u);
  assign b   = hi_mode ? (R - uc) : (R + uc);
  assign n   = rand_mode ? ($signed(32'(lfsr % 16'(NSPAN))) - NMAX) : 0;
  assign dsp = (b * n) / NMAX;
  assign s1  = b + dsp;
  assign s2  = PER - b + dsp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt          <= CW'(PER - 1);
      e1           <= '0;
      e2           <= '0;
      inner        <= 1'b1;
      lfsr         <= SEED;
      period_start <= 1'b0;
      pwm_out      <= 1'b0;
    end else begin
      period_start <= boundary;
      pwm_out      <= (cnt >= e1 && cnt < e2) ? inner : ~inner;
      if (boundary) begin
        cnt   <= '0;
        e1    <= CW'(s1);
        e2    <= CW'(s2);
        inner <= hi_mode;
        lfsr  <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      end else if (tick_en) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rcd_pwm_chk.sv
module rcd_pwm_chk #(
  parameter int PER = 1000,
  parameter int CW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_en,
  input logic          period_start,
  input logic          pwm_out,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] e1,
  input logic [CW-1:0] e2,
  input logic [15:0]   lfsr
);
  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |=> !period_start);

  assert_strobe_at_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |-> (cnt == '0));

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(PER));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> ($stable(cnt) && !period_start));

  assert_latch_at_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick_en && cnt == CW'(PER - 1)) |=> ($stable(e1) && $stable(e2)));

  assert_window_in_period_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (e1 <= e2) && (e2 <= CW'(PER)));

  assert_lfsr_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != 16'h0);

  assert_pwm_known_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(pwm_out));
endmodule

bind rcd_pwm rcd_pwm_chk #(.PER(PER), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .period_start(period_start),
  .pwm_out(pwm_out), .cnt(cnt), .e1(e1), .e2(e2), .lfsr(lfsr)
);

// File: tb/tb_rcd_pwm.sv
module tb_rcd_pwm;
  localparam int CLK_PERIOD = 10;
  localparam int R = 250;
  localparam int PER = 4 * R;
  localparam int NV = 13;
  localparam int VREF [NV] = '{0, 100, -100, 250, -250, 255, -256, 0, 120, -180, 60, 250, -250};
  localparam bit VMOD [NV] = '{0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 1};
  localparam bit VPOL [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0};

  logic clk = 0, rst_n = 0, tick_en = 0, rand_mode = 0, disp_high = 0;
  logic signed [8:0] ref_in = '0;
  logic pwm_out, period_start;
  int nchk = 0, nfail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rcd_pwm dut (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ref_in(ref_in),
               .rand_mode(rand_mode), .disp_high(disp_high),
               .pwm_out(pwm_out), .period_start(period_start));

  function automatic int clampr(int v);
    return (v > R) ? R : ((v < -R) ? -R : v);
  endfunction

  function automatic logic [15:0] lfsr_step(logic [15:0] x);
    return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
  endfunction

  int mcnt, me1, me2;
  bit minner, exp_pwm, exp_ps;
  logic [15:0] mlfsr;
  always @(posedge clk) begin
    if (!rst_n) begin
      mcnt <= PER - 1; me1 <= 0; me2 <= 0; minner <= 1;
      mlfsr <= 16'hACE1; exp_pwm <= 0; exp_ps <= 0;
    end else begin
      int uc, bb, nn, dd;
      exp_ps  <= tick_en && mcnt == PER - 1;
      exp_pwm <= (mcnt >= me1 && mcnt < me2) ? minner : !minner;
      if (tick_en && mcnt == PER - 1) begin
        uc = clampr(int'(ref_in));
        bb = (rand_mode && disp_high) ? R - uc : R + uc;
        nn = rand_mode ? int'(mlfsr % 16'd201) - 100 : 0;
        dd = (bb * nn) / 100;
        me1 <= bb + dd;
        me2 <= PER - bb + dd;
        minner <= rand_mode && disp_high;
        mlfsr <= lfsr_step(mlfsr);
        mcnt <= 0;
      end else if (tick_en) begin
        mcnt <= mcnt + 1;
      end
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic wait_ps();
    do @(negedge clk); while (period_start !== 1'b1);
  endtask

  task automatic measure(input int hold_at, input int chg_at, input int chg_val,
                         output int hi, output int mism, output int first_low,
                         output int len, output int unstable);
    int k = 0;
    bit held = 0;
    hi = 0; mism = 0; first_low = -1; unstable = 0;
    forever begin
      @(negedge clk);
      k++;
      if (pwm_out !== exp_pwm || period_start !== exp_ps) mism++;
      if (hold_at >= 0 && k == hold_at + 2) held = pwm_out;
      if (hold_at >= 0 && k > hold_at + 1 && k <= hold_at + 40 &&
          (pwm_out !== held || period_start !== 1'b0)) unstable++;
      if (pwm_out === 1'b1) hi++;
      if (first_low < 0 && pwm_out === 1'b0) first_low = k - 1;
      if (k == hold_at) tick_en = 0;
      if (hold_at >= 0 && k == hold_at + 40) tick_en = 1;
      if (k == chg_at) ref_in = 9'(chg_val);
      if (period_start === 1'b1) break;
    end
    len = k;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL R2 watchdog: actual %0d cycles expected completion", 190000);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int hi, mism, fl, len, uns, uc;
    int fpos [6];
    int distinct;
    string tag;
    repeat (5) @(negedge clk);
    chk(pwm_out === 1'b0, "R1", "pwm_out in reset", int'(pwm_out), 0);
    chk(period_start === 1'b0, "R1", "period_start in reset", int'(period_start), 0);
    rst_n = 1;
    uns = 0;
    repeat (5) begin
      @(negedge clk);
      if (pwm_out !== 1'b0 || period_start !== 1'b0) uns++;
    end
    chk(uns == 0, "R1", "idle outputs before first tick", uns, 0);
    tick_en = 1;
    @(negedge clk);
    chk(period_start === 1'b1, "R2", "strobe after first tick", int'(period_start), 1);

    for (int i = 0; i < NV; i++) begin
      ref_in = 9'(VREF[i]); rand_mode = VMOD[i]; disp_high = VPOL[i];
      wait_ps();
      measure(-1, -1, 0, hi, mism, fl, len, uns);
      uc = clampr(VREF[i]);
      tag = (VREF[i] != uc) ? "R6" : ((uc == R || uc == -R) ? "R7" : "R10");
      chk(hi == 2 * (R + uc), tag, $sformatf("high ticks vector %0d", i), hi, 2 * (R + uc));
      chk(len == PER, "R2", $sformatf("period length vector %0d", i), len, PER);
      tag = !VMOD[i] ? "R4" : (VPOL[i] ? "R9" : "R8");
      chk(mism == 0, tag, $sformatf("waveform mismatches vector %0d", i), mism, 0);
      if (!VMOD[i] && uc > -R && uc < R)
        chk(fl == R + uc, "R4", $sformatf("first low tick vector %0d", i), fl, R + uc);
    end

    ref_in = -9'sd100; rand_mode = 0; disp_high = 0;
    wait_ps();
    measure(-1, 100, 200, hi, mism, fl, len, uns);
    chk(hi == 2 * (R - 100), "R5", "mid-period reference change ignored", hi, 2 * (R - 100));
    chk(fl == R - 100, "R5", "edge position kept after change", fl, R - 100);

    ref_in = 9'sd50;
    wait_ps();
    measure(300, -1, 0, hi, mism, fl, len, uns);
    chk(len == PER + 40, "R3", "period stretched by held ticks", len, PER + 40);
    chk(uns == 0, "R3", "outputs stable while ticks held", uns, 0);
    chk(mism == 0, "R3", "waveform across hold", mism, 0);

    ref_in = 9'sd0; rand_mode = 1; disp_high = 0;
    wait_ps();
    for (int p = 0; p < 6; p++) begin
      measure(-1, -1, 0, hi, mism, fl, len, uns);
      fpos[p] = fl;
      chk(mism == 0 && hi == 2 * R, "R8", $sformatf("random period %0d", p), mism, 0);
    end
    distinct = 0;
    for (int p = 1; p < 6; p++) if (fpos[p] != fpos[0]) distinct++;
    chk(distinct > 0, "R11", "pulse position varies", distinct, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule